// File: doc/BRIEF.md
# Copy-Queue Channel Controller

This block is the control engine for one queue of a memory-to-memory copy DMA. Software places descriptors in a ring and advances a submission tail pointer. The controller compares that tail with its own completion head pointer and launches one descriptor at a time on a stubbed copy engine. It waits for the engine to report done or error, then retires the descriptor by moving the head forward.

A small register port exposes the following:
- a first control word holding enable, pause and the error policy;
- a second control word holding a self-clearing queue-reset request;
- a status word that reports the channel's 4-bit state code;
- a pointer word through which software writes the tail and reads both pointers.

Pause and enable are independent. Both let the descriptor already in flight finish. A reset request is held off while a descriptor is running. When it is carried out, the reset returns both pointers to zero. Software can shut a queue down in order: set pause, clear enable, wait until the state has left RUN, request a reset, then release pause.

Top module: `qchan_ctrl`

## Requirements
- R1: Out of reset the state code is IDLE (0), both pointers are 0, both control words read 0 and `engStart` is low. The state codes are IDLE=0, RUN=1, CPL=2, PAUSE=3, HALT=4, ABORT=5, WAIT=6, BUFFCLR=7. They appear on `chanState` and in bits [3:0] of the status word at address 2.
- R2: The control word at address 0 holds enable in bit 0, error-abort in bit 2 and pause in bit 4. Each bit is written and read back on its own, and every other bit reads 0.
- R3: In IDLE, with enable set, pause clear and tail different from head, `engStart` pulses for one cycle and the state moves to RUN on the next edge. With tail equal to head, the state stays IDLE and `engStart` stays low.
- R4: RUN holds until `engDone` or `engErr`. A clean done leads to CPL for one cycle, during which the head advances by one modulo DEPTH. After CPL the state goes to IDLE if enabled and not paused.
- R5: Setting pause during RUN does not stop the in-flight descriptor. After CPL the state holds in PAUSE, with no `engStart`, until pause clears. It then returns to IDLE.
- R6: Clearing enable during RUN lets the descriptor finish, after which the state goes to HALT. HALT launches nothing, even with work pending, and goes to IDLE once enable is set again.
- R7: With error-abort clear, `engErr` in RUN leads to WAIT for one cycle. The errored descriptor is retired (head advances) and the queue continues from IDLE.
- R8: With error-abort set, `engErr` in RUN leads to ABORT. ABORT holds, with the head frozen and no launches, whatever happens to enable, pause or the tail, until a reset request.
- R9: Writing 1 to bit 0 of address 1 requests a queue reset. The request is ignored while in RUN and carried out in any other state as one BUFFCLR cycle. The request bit reads 1 during BUFFCLR. On the following edge the head, the tail and the request bit become 0 and the state becomes IDLE, where it stays with enable set and no new work.
- R10: A write to address 3 sets the tail from bits [PTR_W-1:0]. A read of address 3 returns the tail in bits [PTR_W-1:0] and the head in bits [16+PTR_W-1:16]. Only retirement and reset move the head.
- R11: `engDone` and `engErr` outside RUN have no effect on state or pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 ctrl, 1 reset request, 2 status, 3 pointers) |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for regAddr |
| engDone | input | 1 | Copy engine finished the launched descriptor |
| engErr | input | 1 | Copy engine reported an error on the launched descriptor |
| engStart | output | 1 | One-cycle launch of the descriptor at the head |
| chanState | output | 4 | Current state code |
| sqTail | output | PTR_W | Submission tail pointer |
| cqHead | output | PTR_W | Completion head pointer |

## Verification
The bench pushes more descriptors through the ring than it has slots, so that the head wraps. A design with a bad modulo or a stale start strobe then shows a wrong head or a double launch. It writes pause, enable clear and a reset request while a descriptor is in flight. A design that cuts the descriptor short, or clears the pointers in RUN, leaves RUN early or shows zero pointers too soon. It drives errors under both policies and checks that ABORT is sticky and WAIT retires the descriptor. A design with the policy inverted, or one that lets a tail write restart an aborted queue, visibly changes state. It also pulses the engine inputs while idle to catch a design that retires phantom completions.

// File: rtl/qchan_pkg.sv
package qchan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_RUN    = 4'd1,
    ST_CPL    = 4'd2,
    ST_PAUSE  = 4'd3,
    ST_HALT   = 4'd4,
    ST_ABORT  = 4'd5,
    ST_WAIT   = 4'd6,
    ST_BUFCLR = 4'd7
  } chanState_e;

  // strobes from the control FSM to the pointer/register datapath
  typedef struct packed {
    logic engStart;
    logic headInc;
    logic ptrClr;
  } ctlStrobe_t;

  // configuration and work indication from the datapath to the FSM
  typedef struct packed {
    logic enable;
    logic pause;
    logic abortOnErr;
    logic rstReq;
    logic workPending;
  } chanCfg_t;

  localparam logic [1:0] ADDR_CTL0   = 2'd0;
  localparam logic [1:0] ADDR_CTL1   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_PTRS   = 2'd3;

  localparam int CTL0_EN_BIT    = 0;
  localparam int CTL0_ABORT_BIT = 2;
  localparam int CTL0_PAUSE_BIT = 4;
  localparam int CTL1_RST_BIT   = 0;
  localparam int HEAD_LSB       = 16;

endpackage

// File: rtl/qchan_regs.sv
module qchan_regs
  import qchan_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  ctlStrobe_t        strb,
  input  logic [3:0]        stateCode,
  output chanCfg_t          cfg,
  output logic [PTR_W-1:0]  sqTail,
  output logic [PTR_W-1:0]  cqHead
);

  logic             enableQ, pauseQ, abortQ, rstReqQ;
  logic [PTR_W-1:0] sqTailQ, cqHeadQ;
  logic             wrCtl0, wrCtl1, wrPtrs;

  assign wrCtl0 = regWe && (regAddr == ADDR_CTL0);
  assign wrCtl1 = regWe && (regAddr == ADDR_CTL1);
  assign wrPtrs = regWe && (regAddr == ADDR_PTRS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      pauseQ  <= 1'b0;
      abortQ  <= 1'b0;
    end else if (wrCtl0) begin
      enableQ <= regWdata[CTL0_EN_BIT];
      pauseQ  <= regWdata[CTL0_PAUSE_BIT];
      abortQ  <= regWdata[CTL0_ABORT_BIT];
    end
  end

  // reset request clears itself when the clear cycle completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rstReqQ <= 1'b0;
    else if (strb.ptrClr) rstReqQ <= 1'b0;
    else if (wrCtl1)      rstReqQ <= regWdata[CTL1_RST_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sqTailQ <= '0;
    else if (strb.ptrClr) sqTailQ <= '0;
    else if (wrPtrs)      sqTailQ <= regWdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cqHeadQ <= '0;
    else if (strb.ptrClr)  cqHeadQ <= '0;
    else if (strb.headInc) cqHeadQ <= cqHeadQ + 1'b1;
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTL0: begin
        regRdata[CTL0_EN_BIT]    = enableQ;
        regRdata[CTL0_PAUSE_BIT] = pauseQ;
        regRdata[CTL0_ABORT_BIT] = abortQ;
      end
      ADDR_CTL1:   regRdata[CTL1_RST_BIT] = rstReqQ;
      ADDR_STATUS: regRdata[3:0] = stateCode;
      ADDR_PTRS: begin
        regRdata[PTR_W-1:0]           = sqTailQ;
        regRdata[HEAD_LSB +: PTR_W]   = cqHeadQ;
      end
      default: regRdata = '0;
    endcase
  end

  assign cfg.enable      = enableQ;
  assign cfg.pause       = pauseQ;
  assign cfg.abortOnErr  = abortQ;
  assign cfg.rstReq      = rstReqQ;
  assign cfg.workPending = (sqTailQ != cqHeadQ);
  assign sqTail          = sqTailQ;
  assign cqHead          = cqHeadQ;

  // R9: a clear cycle leaves both pointers and the request at zero
  a_r9_clear_zeroes_ptrs: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrClr |=> (sqTailQ == '0) && (cqHeadQ == '0) && !rstReqQ);

  // R10: register writes never move the head
  a_r10_head_only_by_fsm: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.headInc && !strb.ptrClr) |=> $stable(cqHeadQ));

endmodule

// File: rtl/qchan_fsm.sv
module qchan_fsm
  import qchan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  chanCfg_t   cfg,
  input  logic       engDone,
  input  logic       engErr,
  output ctlStrobe_t strb,
  output logic [3:0] stateCode
);

  chanState_e stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    strb     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cfg.rstReq)                        stateNxt = ST_BUFCLR;
        else if (cfg.enable && cfg.pause)      stateNxt = ST_PAUSE;
        else if (cfg.enable && cfg.workPending) begin
          stateNxt      = ST_RUN;
          strb.engStart = 1'b1;
        end
      end
      ST_RUN: begin
        if (engErr)       stateNxt = cfg.abortOnErr ? ST_ABORT : ST_WAIT;
        else if (engDone) stateNxt = ST_CPL;
      end
      ST_CPL, ST_WAIT: begin
        strb.headInc = 1'b1;
        if (cfg.rstReq)       stateNxt = ST_BUFCLR;
        else if (!cfg.enable) stateNxt = ST_HALT;
        else if (cfg.pause)   stateNxt = ST_PAUSE;
        else                  stateNxt = ST_IDLE;
      end
      ST_PAUSE: begin
        if (cfg.rstReq)      stateNxt = ST_BUFCLR;
        else if (!cfg.pause) stateNxt = cfg.enable ? ST_IDLE : ST_HALT;
      end
      ST_HALT: begin
        if (cfg.rstReq)      stateNxt = ST_BUFCLR;
        else if (cfg.enable) stateNxt = ST_IDLE;
      end
      ST_ABORT: begin
        if (cfg.rstReq) stateNxt = ST_BUFCLR;
      end
      ST_BUFCLR: begin
        strb.ptrClr = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign stateCode = stateQ;

  // R3: RUN is only entered from a ready, enabled queue with work
  a_r3_run_entry: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && $past(stateQ) != ST_RUN) |->
      $past(cfg.enable && !cfg.pause && cfg.workPending));

  // R4 / R9: RUN is only left through an engine response
  a_r4_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && !engDone && !engErr) |=> stateQ == ST_RUN);

  // R5: nothing launches while paused
  a_r5_pause_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PAUSE) |-> !strb.engStart);

  // R8: abort is sticky until a reset request
  a_r8_abort_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ABORT && !cfg.rstReq) |=> stateQ == ST_ABORT);

endmodule

// File: rtl/qchan_ctrl.sv
module qchan_ctrl
  import qchan_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic [1:0]                 regAddr,
  input  logic [DATA_W-1:0]          regWdata,
  output logic [DATA_W-1:0]          regRdata,
  input  logic                       engDone,
  input  logic                       engErr,
  output logic                       engStart,
  output logic [3:0]                 chanState,
  output logic [$clog2(DEPTH)-1:0]   sqTail,
  output logic [$clog2(DEPTH)-1:0]   cqHead
);

  localparam int PTR_W = $clog2(DEPTH);

  ctlStrobe_t strb;
  chanCfg_t   cfg;
  logic [3:0] stateCode;

  qchan_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strb     (strb),
    .stateCode(stateCode),
    .cfg      (cfg),
    .sqTail   (sqTail),
    .cqHead   (cqHead)
  );

  qchan_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .engDone  (engDone),
    .engErr   (engErr),
    .strb     (strb),
    .stateCode(stateCode)
  );

  assign engStart  = strb.engStart;
  assign chanState = stateCode;

  // R1: the pointer ring needs a power-of-two depth to wrap by width
  initial begin
    a_r1_depth_pow2: assert ((1 << PTR_W) == DEPTH);
  end

endmodule

// File: tb/qchan_ctrl_bench.sv
module qchan_ctrl_bench;

  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          engDone = 1'b0;
  logic          engErr = 1'b0;
  logic          engStart;
  logic [3:0]    chanState;
  logic [PW-1:0] sqTail, cqHead;

  int nChecks = 0;
  int nFail   = 0;
  int expHead = 0;
  int expTail = 0;
  logic [DW-1:0] rv;

  always #2 clk = ~clk;

  qchan_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) u_qchan_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engDone(engDone),
    .engErr(engErr), .engStart(engStart), .chanState(chanState),
    .sqTail(sqTail), .cqHead(cqHead)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseDone();
    engDone = 1'b1; @(negedge clk); engDone = 1'b0;
  endtask

  task automatic pulseErr();
    engErr = 1'b1; @(negedge clk); engErr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 state", chanState, 0);
    chk("R1 head", cqHead, 0);
    chk("R1 tail", sqTail, 0);
    chk("R1 start", engStart, 0);
    rd(2'd0, rv); chk("R1 ctl0", rv, 0);
    rd(2'd1, rv); chk("R1 ctl1", rv, 0);

    // R2 control bits
    wr(2'd0, 32'h15); rd(2'd0, rv); chk("R2 all bits", rv, 32'h15);
    wr(2'd0, 32'h04); rd(2'd0, rv); chk("R2 abort only", rv, 32'h04);
    wr(2'd0, 32'hFFFF_FFEA); rd(2'd0, rv); chk("R2 other bits", rv, 0);
    wr(2'd0, 32'h01); rd(2'd0, rv); chk("R2 enable only", rv, 32'h01);
    step(); step();
    chk("R1 status code idle", chanState, 0);
    rd(2'd2, rv); chk("R1 status word", rv, chanState);

    // R3 empty queue stays idle
    repeat (3) begin
      step();
      chk("R3 empty idle", chanState, 0);
      chk("R3 empty no start", engStart, 0);
    end

    // R3 R4 R10 single descriptors, wrapping the ring
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      expTail = (expHead + 1) % DEPTH;
      wr(2'd3, expTail);
      chk("R3 start pulse", engStart, 1);
      chk("R3 still idle", chanState, 0);
      step();
      chk("R3 run", chanState, 1);
      chk("R3 start single", engStart, 0);
      step(); step();
      chk("R4 run holds", chanState, 1);
      pulseDone();
      chk("R4 cpl", chanState, 2);
      chk("R4 head not yet", cqHead, expHead);
      step();
      expHead = (expHead + 1) % DEPTH;
      chk("R4 back idle", chanState, 0);
      chk("R4 head wraps", cqHead, expHead);
      rd(2'd3, rv);
      chk("R10 ptr word", rv, (expHead << 16) | expTail);
    end

    // R4 three queued descriptors back to back
    expTail = (expHead + 3) % DEPTH;
    wr(2'd3, expTail);
    for (int j = 0; j < 3; j++) begin
      chk("R4 queued start", engStart, 1);
      step();
      chk("R4 queued run", chanState, 1);
      pulseDone();
      chk("R4 queued cpl", chanState, 2);
      step();
      expHead = (expHead + 1) % DEPTH;
      chk("R4 queued head", cqHead, expHead);
    end
    chk("R4 drained", engStart, 0);

    // R11 engine inputs ignored outside RUN
    engDone = 1'b1; engErr = 1'b1;
    step(); step();
    engDone = 1'b0; engErr = 1'b0;
    chk("R11 state", chanState, 0);
    chk("R11 head", cqHead, expHead);

    // R5 pause during run
    expTail = (expHead + 2) % DEPTH;
    wr(2'd3, expTail);
    step();
    chk("R5 run", chanState, 1);
    wr(2'd0, 32'h11);
    chk("R5 in-flight continues", chanState, 1);
    pulseDone();
    chk("R5 cpl", chanState, 2);
    step();
    expHead = (expHead + 1) % DEPTH;
    chk("R5 paused", chanState, 3);
    step(); step();
    chk("R5 holds pause", chanState, 3);
    chk("R5 no start", engStart, 0);
    chk("R5 head", cqHead, expHead);
    wr(2'd0, 32'h01);
    chk("R5 pause release edge", chanState, 3);
    step();
    chk("R5 idle after release", chanState, 0);
    chk("R5 restart", engStart, 1);
    step();
    pulseDone();
    step();
    expHead = (expHead + 1) % DEPTH;
    chk("R5 second done", cqHead, expHead);

    // R6 enable cleared during run
    expTail = (expHead + 2) % DEPTH;
    wr(2'd3, expTail);
    step();
    chk("R6 run", chanState, 1);
    wr(2'd0, 32'h00);
    chk("R6 in-flight continues", chanState, 1);
    pulseDone();
    step();
    expHead = (expHead + 1) % DEPTH;
    chk("R6 halt", chanState, 4);
    step();
    chk("R6 halt holds", chanState, 4);
    chk("R6 no start", engStart, 0);
    wr(2'd0, 32'h01);
    chk("R6 halt at write edge", chanState, 4);
    step();
    chk("R6 idle", chanState, 0);
    chk("R6 start", engStart, 1);
    step();
    pulseDone();
    step();
    expHead = (expHead + 1) % DEPTH;
    chk("R6 head", cqHead, expHead);

    // R7 error with continue policy
    expTail = (expHead + 1) % DEPTH;
    wr(2'd3, expTail);
    step();
    pulseErr();
    chk("R7 wait", chanState, 6);
    step();
    expHead = (expHead + 1) % DEPTH;
    chk("R7 idle", chanState, 0);
    chk("R7 head retired", cqHead, expHead);

    // R8 error with abort policy
    wr(2'd0, 32'h05);
    expTail = (expHead + 1) % DEPTH;
    wr(2'd3, expTail);
    chk("R8 start", engStart, 1);
    step();
    pulseErr();
    chk("R8 abort", chanState, 5);
    wr(2'd0, 32'h15);
    expTail = (expHead + 3) % DEPTH;
    wr(2'd3, expTail);
    wr(2'd0, 32'h01);
    step(); step();
    chk("R8 sticky", chanState, 5);
    chk("R8 no start", engStart, 0);
    chk("R8 head frozen", cqHead, expHead);

    // R9 reset out of ABORT
    wr(2'd1, 32'h1);
    rd(2'd1, rv); chk("R9 req set", rv, 1);
    chk("R9 abort at write", chanState, 5);
    step();
    chk("R9 bufclr", chanState, 7);
    rd(2'd1, rv); chk("R9 req during clr", rv, 1);
    step();
    expHead = 0; expTail = 0;
    chk("R9 idle", chanState, 0);
    chk("R9 head zero", cqHead, 0);
    chk("R9 tail zero", sqTail, 0);
    rd(2'd1, rv); chk("R9 req self-clear", rv, 0);
    repeat (3) step();
    chk("R9 settles idle", chanState, 0);
    chk("R9 no start", engStart, 0);

    // R9 reset requested during RUN is deferred
    wr(2'd3, 32'd2);
    step();
    chk("R9 run", chanState, 1);
    wr(2'd1, 32'h1);
    step(); step();
    chk("R9 run not reset", chanState, 1);
    chk("R9 tail kept", sqTail, 2);
    pulseDone();
    chk("R9 cpl", chanState, 2);
    step();
    chk("R9 deferred clr", chanState, 7);
    step();
    chk("R9 idle after defer", chanState, 0);
    chk("R9 head after defer", cqHead, 0);
    chk("R9 tail after defer", sqTail, 0);

    summary();
    $finish;
  end

endmodule